// File: doc/BRIEF.md
# Presettable Two-Section Ripple Counter

This block is a 4-bit counter made of two sections, each with its own count input. The low section is a divide-by-two stage on output bit 0. The high section drives output bits 3..1, and a parameter makes it either a divide-by-five stage (decade variant) or a divide-by-eight stage (binary variant). Both count inputs advance their section on a high-to-low transition. The user wires the outputs back into the count inputs to pick the counting code. Bit 0 into the high section's input gives BCD in the decade variant and 4-bit binary in the binary variant. Bit 3 into the low section's input gives bi-quinary counting in the decade variant.

The block runs on a free-running system clock. Both count inputs pass through synchronisers, and a falling edge is recognised from two successive synchronised samples. Chained sections therefore ripple with a fixed delay per stage. An active-low clear and an active-low parallel load are sampled on every system clock. They take precedence over counting, and the clear takes precedence over the load.

Top module: `split_ripple_counter`

## Requirements
- R1: While `rst` is high, `q` becomes 0 at the next clock, and no count edge is recognised.
- R2: A high-to-low transition on `cp_lo` toggles `q[0]`. The change appears at the third rising clock edge after the input changes (two synchroniser flops, then the output register). A low-to-high transition changes nothing.
- R3: In the decade variant (`DECADE`=1), each falling edge on `cp_hi` steps `q[3:1]` through the binary values 0,1,2,3,4 and then back to 0, with `q[1]` as the least significant bit.
- R4: In the decade variant, if `q[3:1]` holds 5, 6 or 7, the next falling edge on `cp_hi` sets it to 0.
- R5: In the binary variant (`DECADE`=0), each falling edge on `cp_hi` increments `q[3:1]` modulo 8.
- R6: While `clr_n` is low, `q` becomes 0 at the next clock whatever `load_n`, `d`, `cp_lo` and `cp_hi` do. A falling count edge that is recognised while `clr_n` is low is discarded.
- R7: While `load_n` is low and `clr_n` is high, `q` takes the value of `d` at the next clock, tracks later changes of `d`, and ignores count edges.
- R8: With `q[0]` wired to `cp_hi` in the decade variant, falling edges on `cp_lo` make `q` count 0 to 9 in BCD and then wrap to 0.
- R9: With `q[0]` wired to `cp_hi` in the binary variant, falling edges on `cp_lo` make `q` count 0 to 15 and then wrap to 0.
- R10: With `q[3]` wired to `cp_lo` in the decade variant, `q[0]` toggles once every five falling edges on `cp_hi`. This gives a square wave on `q[0]` at one tenth of the `cp_hi` edge rate, with equal high and low times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cp_lo | input | 1 | Count input of the divide-by-two section, falling-edge active |
| cp_hi | input | 1 | Count input of the high section, falling-edge active |
| clr_n | input | 1 | Active-low clear, highest priority |
| load_n | input | 1 | Active-low parallel load |
| d | input | 4 | Parallel load value |
| q | output | 4 | Counter state (bit 0 from the low section, bits 3..1 from the high section) |

## Verification
Two things are hard to reach from the ports. One is the recovery of the decade section from the unused codes 5 to 7, which normal counting never produces. The bench reaches it by presetting each unused code with the load, releasing the load, and giving a single high-section edge; it does this with bit 0 both clear and set. The other is the chained modes. There, an output's own falling edge must ripple through a second synchroniser, so the bench builds the feedback wiring around both variants. It changes that wiring only while the clear holds every output and count input low, so the switch creates no false edge.

// File: rtl/split_cnt_pkg.sv
package split_cnt_pkg;
  localparam int LO_W  = 1;
  localparam int HI_W  = 3;
  localparam int CNT_W = LO_W + HI_W;

  // divide-by-five step; unused codes fall back to zero
  function automatic logic [HI_W-1:0] quinary_next(input logic [HI_W-1:0] v);
    if (v >= HI_W'(4)) return '0;
    return v + HI_W'(1);
  endfunction

  // divide-by-eight step
  function automatic logic [HI_W-1:0] octal_next(input logic [HI_W-1:0] v);
    return v + HI_W'(1);
  endfunction
endpackage

// File: rtl/cnt_edge_sync.sv
module cnt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign fall = last & ~chain[STAGES-1];
endmodule

// File: rtl/cnt_lo_stage.sv
module cnt_lo_stage (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic load,
  input  logic pval,
  input  logic adv,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= 1'b0;
    else if (load)  q <= pval;
    else if (adv)   q <= ~q;
  end
endmodule

// File: rtl/cnt_hi_stage.sv
module cnt_hi_stage
  import split_cnt_pkg::*;
#(
  parameter bit DECADE = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            load,
  input  logic [HI_W-1:0] pval,
  input  logic            adv,
  output logic [HI_W-1:0] q
);
  logic [HI_W-1:0] q_step;

  generate
    if (DECADE) begin : g_div5
      always_comb q_step = quinary_next(q);
    end else begin : g_div8
      always_comb q_step = octal_next(q);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (load)  q <= pval;
    else if (adv)   q <= q_step;
  end
endmodule

// File: rtl/split_ripple_counter.sv
module split_ripple_counter
  import split_cnt_pkg::*;
#(
  parameter bit DECADE      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cp_lo,
  input  logic             cp_hi,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [CNT_W-1:0] d,
  output logic [CNT_W-1:0] q
);
  logic fall_lo, fall_hi;
  logic clr, load;
  logic q_lo;
  logic [HI_W-1:0] q_hi;

  assign clr  = ~clr_n;
  assign load = clr_n & ~load_n;

  cnt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_lo (
    .clk(clk), .rst(rst), .din(cp_lo), .fall(fall_lo)
  );

  cnt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_hi (
    .clk(clk), .rst(rst), .din(cp_hi), .fall(fall_hi)
  );

  cnt_lo_stage u_lo (
    .clk(clk), .rst(rst), .clr(clr), .load(load),
    .pval(d[0]), .adv(fall_lo), .q(q_lo)
  );

  cnt_hi_stage #(.DECADE(DECADE)) u_hi (
    .clk(clk), .rst(rst), .clr(clr), .load(load),
    .pval(d[CNT_W-1:LO_W]), .adv(fall_hi), .q(q_hi)
  );

  assign q = {q_hi, q_lo};
endmodule

// File: rtl/split_ripple_counter_chk.sv
module split_ripple_counter_chk #(
  parameter bit DECADE = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       clr_n,
  input logic       load_n,
  input logic [3:0] d,
  input logic [3:0] q,
  input logic       fall_lo,
  input logic       fall_hi
);
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> q == 4'd0);

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> q == 4'd0);

  a_r7_load_follows: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !load_n) |=> q == $past(d));

  a_r2_lo_toggles: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && fall_lo) |=> q[0] != $past(q[0]));

  a_r2_lo_holds: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && !fall_lo) |=> $stable(q[0]));

  a_r4_dec_in_range: assert property (@(posedge clk) disable iff (rst)
    (DECADE && clr_n && load_n && fall_hi) |=> q[3:1] <= 3'd4);

  a_r5_bin_step: assert property (@(posedge clk) disable iff (rst)
    (!DECADE && clr_n && load_n && fall_hi) |=> q[3:1] == $past(q[3:1]) + 3'd1);
endmodule

bind split_ripple_counter split_ripple_counter_chk #(.DECADE(DECADE)) u_chk (
  .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n), .d(d), .q(q),
  .fall_lo(fall_lo), .fall_hi(fall_hi)
);

// File: tb/tb_split_ripple_counter.sv
module tb_split_ripple_counter;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    bit         which;
    logic [3:0] exp;
    string      tag;
  } sb_item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_n = 1'b1, load_n = 1'b1;
  logic [3:0] d = 4'd0;
  logic cp0_drv = 1'b0, cp1_drv = 1'b0;
  bit chain_mode = 1'b0, bq_mode = 1'b0;
  logic [3:0] q_d, q_b;
  logic cpd_lo, cpd_hi, cpb_hi;

  sb_item_t sb[$];
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cpd_lo = bq_mode    ? q_d[3] : cp0_drv;
  assign cpd_hi = chain_mode ? q_d[0] : cp1_drv;
  assign cpb_hi = chain_mode ? q_b[0] : cp1_drv;

  split_ripple_counter #(.DECADE(1'b1)) dut (
    .clk(clk), .rst(rst), .cp_lo(cpd_lo), .cp_hi(cpd_hi),
    .clr_n(clr_n), .load_n(load_n), .d(d), .q(q_d)
  );

  split_ripple_counter #(.DECADE(1'b0)) dut_bin (
    .clk(clk), .rst(rst), .cp_lo(cp0_drv), .cp_hi(cpb_hi),
    .clr_n(clr_n), .load_n(load_n), .d(d), .q(q_b)
  );

  // monitor: compare every queued expectation at the falling clock edge
  always @(negedge clk) begin
    sb_item_t it;
    logic [3:0] act;
    while (sb.size() != 0) begin
      it = sb.pop_front();
      act = it.which ? q_b : q_d;
      n_tests++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s (%s): actual %h expected %h", it.tag,
                 it.which ? "binary" : "decade", act, it.exp);
      end
    end
  end

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input bit which, input logic [3:0] e, input string tag);
    sb_item_t it;
    it.which = which; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic pulse0();
    @(negedge clk) cp0_drv = 1'b1;
    settle(4);
    @(negedge clk) cp0_drv = 1'b0;
    settle(10);
  endtask

  task automatic pulse1();
    @(negedge clk) cp1_drv = 1'b1;
    settle(4);
    @(negedge clk) cp1_drv = 1'b0;
    settle(10);
  endtask

  initial begin
    settle(3);
    push(0, 4'h0, "R1"); push(1, 4'h0, "R1");
    @(negedge clk) rst = 1'b0;
    settle(2);

    // R2: latency and falling-edge only
    @(negedge clk) cp0_drv = 1'b1;
    settle(5);
    push(0, 4'h0, "R2 rise"); push(1, 4'h0, "R2 rise");
    @(negedge clk) cp0_drv = 1'b0;
    settle(2);
    push(0, 4'h0, "R2 early"); push(1, 4'h0, "R2 early");
    settle(1);
    push(0, 4'h1, "R2 edge"); push(1, 4'h1, "R2 edge");
    pulse0();
    push(0, 4'h0, "R2 second"); push(1, 4'h0, "R2 second");

    // R3 / R5: high sections on their own
    for (int k = 1; k <= 8; k++) begin
      pulse1();
      push(0, 4'((k % 5) << 1), "R3");
      push(1, 4'((k % 8) << 1), "R5");
    end

    // R7: load overrides and tracks d
    @(negedge clk) begin load_n = 1'b0; d = 4'hB; end
    settle(1);
    push(0, 4'hB, "R7 load"); push(1, 4'hB, "R7 load");
    pulse0(); pulse1();
    push(0, 4'hB, "R7 no count"); push(1, 4'hB, "R7 no count");
    @(negedge clk) d = 4'h6;
    settle(1);
    push(0, 4'h6, "R7 track"); push(1, 4'h6, "R7 track");

    // R4: unused decade codes recover to zero
    for (int v = 5; v <= 7; v++) begin
      for (int b = 0; b <= 1; b++) begin
        @(negedge clk) begin load_n = 1'b0; d = {3'(v), 1'(b)}; end
        settle(1);
        @(negedge clk) load_n = 1'b1;
        pulse1();
        push(0, {3'd0, 1'(b)}, "R4");
        push(1, {3'((v + 1) % 8), 1'(b)}, "R5 wrap");
      end
    end

    // R6: clear wins over load and swallows edges
    @(negedge clk) begin clr_n = 1'b0; load_n = 1'b0; d = 4'hF; end
    settle(1);
    push(0, 4'h0, "R6 over load"); push(1, 4'h0, "R6 over load");
    @(negedge clk) load_n = 1'b1;
    pulse0(); pulse1();
    push(0, 4'h0, "R6 hold"); push(1, 4'h0, "R6 hold");
    @(negedge clk) cp1_drv = 1'b1;
    settle(4);
    @(negedge clk) cp1_drv = 1'b0;
    settle(4);
    @(negedge clk) clr_n = 1'b1;
    settle(6);
    push(0, 4'h0, "R6 lost edge"); push(1, 4'h0, "R6 lost edge");

    // R8 / R9: q0 chained into the high section
    @(negedge clk) clr_n = 1'b0;
    settle(2);
    @(negedge clk) chain_mode = 1'b1;
    settle(2);
    @(negedge clk) clr_n = 1'b1;
    settle(2);
    for (int k = 1; k <= 16; k++) begin
      pulse0();
      push(0, 4'(k % 10), "R8");
      push(1, 4'(k % 16), "R9");
    end

    // R10: bi-quinary, q3 chained into the low section
    @(negedge clk) clr_n = 1'b0;
    settle(2);
    @(negedge clk) begin chain_mode = 1'b0; bq_mode = 1'b1; end
    settle(2);
    @(negedge clk) clr_n = 1'b1;
    settle(2);
    for (int k = 1; k <= 10; k++) begin
      pulse1();
      push(0, {3'(k % 5), 1'((k % 10) >= 5)}, "R10");
      push(1, {3'(k % 8), 1'b0}, "R5 bq");
    end

    settle(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule